// File: doc/BRIEF.md
# PS/2 Host-to-Device Byte Transmitter

This block sends a single command byte from a host to a PS/2 keyboard or mouse over the two open-drain bus lines. It never drives a line high. Each line has a pull enable: when the enable is asserted the pad pulls the line to ground, and when it is cleared the external pull-up restores the line.

A transfer begins once a byte is accepted on the request handshake. The block first holds the clock line low for a fixed inhibit interval. It then pulls the data line low as the start bit and lets the clock go. From that point the device produces the clock, and the block advances only on qualified falling edges of that clock. On each edge it presents the next data bit, then the odd parity bit, then a released stop bit. On the eleventh edge it reads the device's acknowledge. A negative acknowledge, or a clock gap that shows an edge was missed, releases the data line and restarts the whole sequence with the same byte. When the acknowledge arrives, the block releases both lines and pulses `done`. If the byte is still unacknowledged when a long deadline measured from acceptance expires, the block abandons it, releases both lines and pulses `timeout`.

All intervals are counted in cycles of the system clock and set by parameters. The defaults assume a 1 MHz system clock.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `req_ready` is 1 and both `clk_pull` and `dat_pull` are 0.
- R2: A byte is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` then stays 0 until the transfer ends with `done` or `timeout`.
- R3: After a byte is accepted, `clk_pull` is 1 for INHIBIT_CYC cycles (one more is tolerated). In the cycle that `clk_pull` returns to 0, `dat_pull` becomes 1, which places the start bit (a low data line) on the bus.
- R4: A falling edge on `clk_in` that comes fewer than FIRST_EDGE_MIN_CYC cycles after the clock is released is ignored and does not advance the bit sequence.
- R5: On accepted falling edges 1 to 8, the data line carries the byte least significant bit first. `dat_pull` is 1 when the bit is 0 and 0 when the bit is 1.
- R6: On accepted edge 9, the line carries odd parity, so that data plus parity hold an odd number of ones. On edge 10 the data line is released, giving a high stop bit.
- R7: If `dat_in` is 0 at accepted edge 11, the block pulses `done` for one cycle, releases both lines and returns to idle with `req_ready` at 1.
- R8: If `dat_in` is 1 at accepted edge 11, the block does not signal `done`. It releases data and sends the same byte again, starting from the clock inhibit.
- R9: A falling edge fewer than EDGE_GAP_MIN_CYC cycles after the last accepted edge is ignored.
- R10: Once at least one edge has been accepted, if more than EDGE_GAP_MAX_CYC cycles pass without a new accepted edge, the block releases data and restarts the same byte from the clock inhibit.
- R11: If no acknowledge arrives within TIMEOUT_CYC cycles of acceptance, the block pulses `timeout` for one cycle, releases both lines and returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A byte is offered for transmission |
| req_data | input | 8 | The byte to send |
| req_ready | output | 1 | The block is idle and can accept a byte |
| clk_pull | output | 1 | Pull the bus clock line low |
| dat_pull | output | 1 | Pull the bus data line low |
| clk_in | input | 1 | Bus clock line level, already synchronized |
| dat_in | input | 1 | Bus data line level, already synchronized |
| done | output | 1 | One-cycle pulse: byte acknowledged |
| timeout | output | 1 | One-cycle pulse: byte abandoned at the deadline |

## Verification
The assertions assume the following about the inputs:
- `clk_in` and `dat_in` already hold clean synchronized levels.
- The line levels are the wired-AND of the block's own pull enables and the device's drivers.
- `req_valid` is only a request. Nothing in the block depends on it being held.

The stimulus respects these assumptions:
- A bench device model drives its own clock and data through that same wired-AND.
- The device changes the bus only between system clock edges.
- The device waits for the clock release before it produces edges. It places deliberate early, glitch and stall edges relative to the block's parameter windows, set small for the bench, so that each filter rule is hit on one side of its boundary.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_INHIBIT = 2'd1,
    TX_SHIFT   = 2'd2
  } tx_state_e;

  typedef logic [3:0] bit_idx_t;

  // Position of each frame slot in the edge count
  localparam bit_idx_t IDX_FIRST_DATA = 4'd1;
  localparam bit_idx_t IDX_PARITY     = 4'd9;
  localparam bit_idx_t IDX_STOP       = 4'd10;
  localparam bit_idx_t IDX_ACK        = 4'd11;

endpackage

// File: rtl/ps2tx_edge_qual.sv
// Qualifies falling edges of the device clock: early and closely spaced
// edges are dropped, a long gap after the first accepted edge is flagged.
module ps2tx_edge_qual #(
  parameter int unsigned FIRST_MIN = 60,
  parameter int unsigned GAP_MIN   = 40,
  parameter int unsigned GAP_MAX   = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk,
  input  logic arm,
  input  logic track,
  output logic edge_ok,
  output logic gap_err
);
  localparam int unsigned SAT = ((FIRST_MIN > GAP_MAX) ? FIRST_MIN : GAP_MAX) + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V   = CW'(SAT);
  localparam logic [CW-1:0] FIRST_V = CW'(FIRST_MIN);
  localparam logic [CW-1:0] MIN_V   = CW'(GAP_MIN);
  localparam logic [CW-1:0] MAX_V   = CW'(GAP_MAX);

  logic          prev_q, prev_d;
  logic          seen_q, seen_d;
  logic [CW-1:0] since_q, since_d;
  logic          fall;

  always_comb begin
    fall    = prev_q & ~line_clk;
    edge_ok = track && fall && (seen_q ? (since_q >= MIN_V) : (since_q >= FIRST_V));
    gap_err = track && seen_q && (since_q > MAX_V);
  end

  always_comb begin
    prev_d  = line_clk;
    seen_d  = seen_q;
    since_d = since_q;
    if (arm) begin
      seen_d  = 1'b0;
      since_d = '0;
    end else if (edge_ok) begin
      seen_d  = 1'b1;
      since_d = '0;
    end else if (since_q != SAT_V) begin
      since_d = since_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      seen_q  <= 1'b0;
      since_q <= '0;
    end else begin
      prev_q  <= prev_d;
      seen_q  <= seen_d;
      since_q <= since_d;
    end
  end

endmodule

// File: rtl/ps2tx_deadline.sv
// Counts busy cycles from acceptance and flags the last allowed one.
module ps2tx_deadline #(
  parameter int unsigned LIMIT = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int unsigned TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST_V = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    expired = run && (cnt_q == LAST_V);
    cnt_d   = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (run && !expired) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ps2tx_frame_bit.sv
// Maps an edge number to the data-line pull level for that frame slot.
module ps2tx_frame_bit
  import ps2tx_pkg::*;
(
  input  logic [7:0] byte_val,
  input  bit_idx_t   idx,
  output logic       pull,
  output logic       legal
);
  logic [15:0] pull_vec;

  assign pull_vec[0] = 1'b0;
  for (genvar g = 0; g < 8; g++) begin : g_data
    assign pull_vec[g + 1] = ~byte_val[g];
  end
  assign pull_vec[IDX_PARITY]  = ^byte_val;
  assign pull_vec[IDX_STOP]    = 1'b0;
  assign pull_vec[15:IDX_ACK]  = '0;

  assign legal = (idx >= IDX_FIRST_DATA) && (idx <= IDX_ACK);
  assign pull  = pull_vec[idx];

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2tx_pkg::*;
#(
  parameter int unsigned INHIBIT_CYC        = 200,
  parameter int unsigned FIRST_EDGE_MIN_CYC = 60,
  parameter int unsigned EDGE_GAP_MIN_CYC   = 40,
  parameter int unsigned EDGE_GAP_MAX_CYC   = 120,
  parameter int unsigned TIMEOUT_CYC        = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_data,
  output logic       req_ready,
  output logic       clk_pull,
  output logic       dat_pull,
  input  logic       clk_in,
  input  logic       dat_in,
  output logic       done,
  output logic       timeout
);
  localparam int unsigned IW = (INHIBIT_CYC > 1) ? $clog2(INHIBIT_CYC) : 1;
  localparam logic [IW-1:0] INH_LAST = IW'(INHIBIT_CYC - 1);

  tx_state_e     state_q, state_d;
  bit_idx_t      bit_q, bit_d;
  logic [7:0]    byte_q, byte_d;
  logic [IW-1:0] inh_q, inh_d;
  logic          dpull_q, dpull_d;
  logic          done_q, done_d;
  logic          tmo_q, tmo_d;

  logic accept, arm, track, edge_ok, gap_err, expired, slot_pull, slot_legal;

  assign accept = req_valid && (state_q == TX_IDLE);
  assign arm    = (state_q == TX_INHIBIT) && (inh_q == INH_LAST);
  assign track  = (state_q == TX_SHIFT);

  ps2tx_edge_qual #(
    .FIRST_MIN (FIRST_EDGE_MIN_CYC),
    .GAP_MIN   (EDGE_GAP_MIN_CYC),
    .GAP_MAX   (EDGE_GAP_MAX_CYC)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_clk (clk_in),
    .arm      (arm),
    .track    (track),
    .edge_ok  (edge_ok),
    .gap_err  (gap_err)
  );

  ps2tx_deadline #(
    .LIMIT (TIMEOUT_CYC)
  ) u_deadline (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .run     (state_q != TX_IDLE),
    .expired (expired)
  );

  ps2tx_frame_bit u_frame (
    .byte_val (byte_q),
    .idx      (bit_q),
    .pull     (slot_pull),
    .legal    (slot_legal)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    inh_d   = inh_q;
    dpull_d = dpull_q;
    done_d  = 1'b0;
    tmo_d   = 1'b0;

    unique case (state_q)
      TX_IDLE: begin
        if (accept) begin
          byte_d  = req_data;
          state_d = TX_INHIBIT;
          inh_d   = '0;
          dpull_d = 1'b0;
        end
      end
      TX_INHIBIT: begin
        if (inh_q == INH_LAST) begin
          state_d = TX_SHIFT;
          dpull_d = 1'b1;          // start bit, clock released together
          bit_d   = IDX_FIRST_DATA;
        end else begin
          inh_d = inh_q + 1'b1;
        end
      end
      TX_SHIFT: begin
        if (gap_err || (edge_ok && (!slot_legal || (bit_q == IDX_ACK && dat_in)))) begin
          state_d = TX_INHIBIT;    // retry same byte
          inh_d   = '0;
          dpull_d = 1'b0;
          bit_d   = IDX_FIRST_DATA;
        end else if (edge_ok) begin
          if (bit_q == IDX_ACK) begin
            state_d = TX_IDLE;
            dpull_d = 1'b0;
            done_d  = 1'b1;
          end else begin
            dpull_d = slot_pull;
            bit_d   = bit_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = TX_IDLE;
        dpull_d = 1'b0;
      end
    endcase

    if (expired) begin
      state_d = TX_IDLE;
      dpull_d = 1'b0;
      done_d  = 1'b0;
      tmo_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      bit_q   <= IDX_FIRST_DATA;
      byte_q  <= '0;
      inh_q   <= '0;
      dpull_q <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      inh_q   <= inh_d;
      dpull_q <= dpull_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  assign req_ready = (state_q == TX_IDLE);
  assign clk_pull  = (state_q == TX_INHIBIT);
  assign dat_pull  = dpull_q;
  assign done      = done_q;
  assign timeout   = tmo_q;

endmodule

// File: rtl/ps2_host_tx_chk.sv
module ps2_host_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       clk_pull,
  input logic       dat_pull,
  input logic       done,
  input logic       timeout,
  input logic [3:0] bit_idx
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!clk_pull && !dat_pull));

  // R2
  accept_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (clk_pull && !req_ready));

  // R3
  start_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_pull) && !timeout) |-> dat_pull);

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !clk_pull) |-> (bit_idx >= 4'd1 && bit_idx <= 4'd11));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !timeout && !clk_pull && !dat_pull));

  // R11
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (req_ready && !clk_pull && !dat_pull));

endmodule

bind ps2_host_tx ps2_host_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .clk_pull  (clk_pull),
  .dat_pull  (dat_pull),
  .done      (done),
  .timeout   (timeout),
  .bit_idx   (bit_q)
);

// File: tb/ps2_host_tx_test.sv
module ps2_host_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int INH   = 20;
  localparam int FIRST = 12;
  localparam int GMIN  = 8;
  localparam int GMAX  = 24;
  localparam int TMO   = 3000;
  localparam int HALF  = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_data;
  logic       req_ready, clk_pull, dat_pull, done, timeout;
  logic       dev_clk, dev_dat;
  logic       clk_line, dat_line;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int tmo_cnt  = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign clk_line = ~clk_pull & dev_clk;
  assign dat_line = ~dat_pull & dev_dat;

  ps2_host_tx #(
    .INHIBIT_CYC        (INH),
    .FIRST_EDGE_MIN_CYC (FIRST),
    .EDGE_GAP_MIN_CYC   (GMIN),
    .EDGE_GAP_MAX_CYC   (GMAX),
    .TIMEOUT_CYC        (TMO)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_data  (req_data),
    .req_ready (req_ready),
    .clk_pull  (clk_pull),
    .dat_pull  (dat_pull),
    .clk_in    (clk_line),
    .dat_in    (dat_line),
    .done      (done),
    .timeout   (timeout)
  );

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (timeout) tmo_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: queue the expected byte, then offer it on the handshake
  task automatic send_byte(input logic [7:0] b, input int copies);
    for (int i = 0; i < copies; i++) exp_q.push_back(b);
    @(negedge clk);
    req_valid = 1'b1;
    req_data  = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Device model and monitor: plays one frame, pops and compares the byte
  task automatic dev_frame(input bit ack, input bit early, input bit glitch,
                           input int stall_at, input bit chk_len, output bit aborted);
    int n;
    logic [10:0] got;
    logic [7:0]  exp;
    aborted = 1'b0;
    got = '0;
    n = 0;
    while (!clk_pull) @(negedge clk);
    check(!req_ready, "R2", "ready during transfer", req_ready, 0);
    while (clk_pull) begin n++; @(negedge clk); end
    if (chk_len) check(n >= INH && n <= INH + 1, "R3", "inhibit length", n, INH);
    check(dat_line == 1'b0, "R3", "start bit low on release", dat_line, 0);
    repeat (3) @(negedge clk);
    if (early) begin
      dev_clk = 1'b0;
      repeat (2) @(negedge clk);
      dev_clk = 1'b1;
    end
    repeat (16) @(negedge clk);
    for (int e = 1; e <= 11; e++) begin
      if (e == 11) dev_dat = ack ? 1'b0 : 1'b1;
      dev_clk = 1'b0;
      if (glitch && e == 3) begin
        repeat (2) @(negedge clk);
        dev_clk = 1'b1;
        @(negedge clk);
        dev_clk = 1'b0;
        repeat (HALF - 3) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      dev_clk = 1'b1;
      if (e <= 10) got[e] = dat_line;
      repeat (HALF) @(negedge clk);
      dev_dat = 1'b1;
      if (e == stall_at) begin
        for (int k = 0; k < 3 * GMAX; k++) begin
          if (clk_pull) begin aborted = 1'b1; break; end
          @(negedge clk);
        end
        check(aborted, "R10", "retry after missing edge", aborted, 1);
        return;
      end
    end
    exp = exp_q.pop_front();
    check(got[8:1] == exp, "R5", "data bits", got[8:1], exp);
    check(^got[9:1] == 1'b1, "R6", "odd parity", got[9], ~^exp);
    check(got[10] == 1'b1, "R6", "stop bit high", got[10], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ab;
    int base;
    int n;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_data = '0;
    dev_clk = 1'b1;
    dev_dat = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(!clk_pull && !dat_pull, "R1", "lines released after reset", {clk_pull, dat_pull}, 0);

    // Plain transfer with ACK
    base = done_cnt;
    send_byte(8'hA5, 1);
    dev_frame(1'b1, 1'b0, 1'b0, 0, 1'b1, ab);
    check(done_cnt == base + 1, "R7", "done after ACK", done_cnt - base, 1);
    check(req_ready && !clk_pull && !dat_pull, "R7", "idle after ACK", req_ready, 1);

    // Early edge right after release (R4)
    base = done_cnt;
    send_byte(8'h00, 1);
    dev_frame(1'b1, 1'b1, 1'b0, 0, 1'b1, ab);
    check(done_cnt == base + 1, "R4", "early edge ignored, done", done_cnt - base, 1);

    // Glitch edge closely after a real one (R9)
    base = done_cnt;
    send_byte(8'hFF, 1);
    dev_frame(1'b1, 1'b0, 1'b1, 0, 1'b1, ab);
    check(done_cnt == base + 1, "R9", "glitch ignored, done", done_cnt - base, 1);

    // NACK then ACK (R8)
    base = done_cnt;
    send_byte(8'h3C, 2);
    dev_frame(1'b0, 1'b0, 1'b0, 0, 1'b1, ab);
    check(done_cnt == base, "R8", "no done on NACK", done_cnt - base, 0);
    dev_frame(1'b1, 1'b0, 1'b0, 0, 1'b0, ab);
    check(done_cnt == base + 1, "R8", "done after resend", done_cnt - base, 1);

    // Stall after second edge (R10), then complete frame
    base = done_cnt;
    send_byte(8'h81, 1);
    dev_frame(1'b1, 1'b0, 1'b0, 2, 1'b1, ab);
    check(!dat_pull || clk_pull, "R10", "data released on retry", dat_pull, 0);
    dev_frame(1'b1, 1'b0, 1'b0, 0, 1'b0, ab);
    check(done_cnt == base + 1, "R10", "done after retry", done_cnt - base, 1);

    // Deadline without any device clock (R11)
    base = tmo_cnt;
    send_byte(8'h5A, 0);
    n = 1;
    while (!timeout && n < 2 * TMO) begin n++; @(negedge clk); end
    check(n >= TMO - 2 && n <= TMO + 2, "R11", "timeout latency", n, TMO);
    @(negedge clk);
    check(tmo_cnt == base + 1, "R11", "single timeout pulse", tmo_cnt - base, 1);
    check(req_ready && !clk_pull && !dat_pull, "R11", "idle after timeout", req_ready, 1);
    check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule